// File: doc/BRIEF.md
# Multi-Source Acquisition Trigger Unit

This block decides the moment at which a digitizer begins to record. Software arms it with a one-cycle start command. At that moment the block latches a trigger source selection. From then on it watches the chosen source. That source is one of the following:
- an unconditional software start;
- a level crossing on either of two digitized analog channels;
- an edge on an asynchronous TTL trigger pin;
- a level-sensitive match of an 8-bit digital input bus against a programmed pattern.

When the selected condition is met, the block raises a one-cycle trigger event. It also drives a trigger output pin high and then disarms itself. The block then holds a triggered flag until it is armed again.

The two channel samples arrive together on one valid/ready stream. The block has no storage on that path, so it never applies back-pressure: ready is held high out of reset. A beat counts only in a cycle where valid is high. The beat is consumed whether or not the unit is armed. The sending side may leave valid low for any number of cycles, and an idle cycle neither forms nor breaks a crossing. The level, the pattern, the interlace select and the connector direction are plain control inputs. The block reads them live.

Top module: `acq_trigger_unit`

## Requirements
- R1: After reset, `trig_event`, `trig_out`, `armed` and `triggered` are all 0, and `smp_ready` is 1.
- R2: A cycle with `arm`=1 makes `armed`=1 and `triggered`=0 from the next cycle on. It also latches `mode` with this encoding: 0 software, 1 channel A rising, 2 channel A falling, 3 channel B rising, 4 channel B falling, 5 TTL rising, 6 TTL falling, 7 pattern. Codes 8 to 15 never fire.
- R3: In software mode, `trig_event` is 1 in the cycle right after the arming cycle.
- R4: A rising crossing on the selected channel fires the unit. A rising crossing means the previous accepted sample is below `level` and the current one is at or above it, with samples and level compared as two's complement. `trig_event` is 1 in the cycle after the beat that completes the crossing. The other channel has no effect.
- R5: A falling crossing on the selected channel fires the unit with the same timing as R4. A falling crossing means the previous accepted sample is at or above `level` and the current one is below it.
- R6: The first accepted beat after arming has no predecessor, so it never completes a crossing.
- R7: `ttl_in` passes through a two-stage synchronizer. Edges are detected on the synchronized signal. After `ttl_in` changes, `trig_event` is 1 following the third rising clock edge, counting the edge that first samples the new level. An edge of the opposite direction has no effect.
- R8: In pattern mode with `interlace`=0, the unit fires when `dig_in` equals all 8 bits of `pattern`. If the bus already matches at arming time, `trig_event` is 1 in the cycle right after the arming cycle.
- R9: With `interlace`=1, only bits 3:0 of `pattern` and `dig_in` are compared, and bits 7:4 are ignored.
- R10: The unit gives exactly one single-cycle event per arming. After firing, `armed`=0 and `triggered`=1, and further conditions have no effect until the next arm. An unarmed unit never fires.
- R11: `trig_out` rises in the same cycle as `trig_event` and stays high until the next arm. It is forced to 0 while `trig_pin_is_input`=1.
- R12: `smp_ready` is always 1. A beat with `smp_valid`=0 is not taken as a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start command, one-cycle pulse |
| mode | input | 4 | Trigger source select, latched at arm |
| level | input | SAMPLE_W | Signed threshold for the channel crossings |
| pattern | input | DIG_W | Digital compare pattern |
| interlace | input | 1 | Narrows the pattern compare to NARROW_W bits |
| trig_pin_is_input | input | 1 | Trigger connector used as input; suppresses trig_out |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat ready, constant 1 |
| smp_ch_a | input | SAMPLE_W | Channel A sample, two's complement |
| smp_ch_b | input | SAMPLE_W | Channel B sample, two's complement |
| ttl_in | input | 1 | Asynchronous external trigger |
| dig_in | input | DIG_W | Digital input bus |
| trig_event | output | 1 | One-cycle trigger event |
| trig_out | output | 1 | Trigger output pin level |
| armed | output | 1 | Unit is armed and waiting |
| triggered | output | 1 | Unit has fired since the last arm |

## Verification
The bench builds the block with SAMPLE_W=4, DIG_W=8, NARROW_W=4 and SYNC_STAGES=2. With 4-bit samples, every ordered pair of sample values can be tried against several thresholds, including the most negative and most positive codes. This covers all four channel modes, so every sign and boundary case of the crossing compare is reached. The same sweep puts the reverse pair on the unselected channel. An 8-bit bus is small enough to compare all 256 input values against one pattern, once in each compare width. The TTL path is timed edge by edge through the two synchronizer stages.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    TRG_SOFT     = 4'd0,
    TRG_A_RISE   = 4'd1,
    TRG_A_FALL   = 4'd2,
    TRG_B_RISE   = 4'd3,
    TRG_B_FALL   = 4'd4,
    TRG_EXT_RISE = 4'd5,
    TRG_EXT_FALL = 4'd6,
    TRG_PATTERN  = 4'd7
  } trg_mode_e;

  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] ch_rise;
    logic [NUM_CH-1:0] ch_fall;
    logic              ext_rise;
    logic              ext_fall;
    logic              pat_hit;
  } trg_cond_t;

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_rise,
  output logic edge_fall
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign edge_rise = chain_q[STAGES-1] & ~last_q;
  assign edge_fall = ~chain_q[STAGES-1] & last_q;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rise |=> !edge_rise); // R7

  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_fall |=> !edge_fall); // R7

endmodule

// File: rtl/acq_trig_cross.sv
module acq_trig_cross #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                enable,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [SAMPLE_W-1:0] level,
  output logic                cross_rise,
  output logic                cross_fall
);

  logic signed [SAMPLE_W-1:0] prev_q;
  logic                       have_prev_q;
  logic signed [SAMPLE_W-1:0] cur_s;
  logic signed [SAMPLE_W-1:0] lvl_s;
  logic                       prev_below;
  logic                       cur_below;
  logic                       take;

  assign cur_s = $signed(smp);
  assign lvl_s = $signed(level);
  assign take  = enable & smp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
    end else if (take) begin
      prev_q      <= cur_s;
      have_prev_q <= 1'b1;
    end
  end

  always_comb begin
    prev_below = (prev_q < lvl_s);
    cur_below  = (cur_s < lvl_s);
    cross_rise = take & have_prev_q &  prev_below & ~cur_below;
    cross_fall = take & have_prev_q & ~prev_below &  cur_below;
  end

  AST_NO_CROSS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !(cross_rise || cross_fall)); // R6

  AST_CROSS_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_rise || cross_fall) |-> smp_valid); // R12

endmodule

// File: rtl/acq_trig_match.sv
module acq_trig_match #(
  parameter int DIG_W    = 8,
  parameter int NARROW_W = 4
) (
  input  logic [DIG_W-1:0] dig_in,
  input  logic [DIG_W-1:0] pattern,
  input  logic             narrow,
  output logic             hit
);

  localparam logic [DIG_W-1:0] WIDE_MASK   = {DIG_W{1'b1}};
  localparam logic [DIG_W-1:0] NARROW_MASK = WIDE_MASK >> (DIG_W - NARROW_W);

  logic [DIG_W-1:0] mask;
  logic [DIG_W-1:0] diff;

  assign mask = narrow ? NARROW_MASK : WIDE_MASK;
  assign diff = (dig_in ^ pattern) & mask;
  assign hit  = (diff == '0);

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
  import acq_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [MODE_W-1:0] mode,
  input  trg_cond_t         cond,
  input  logic              pin_is_input,
  output logic              armed,
  output logic              triggered,
  output logic              trig_event,
  output logic              trig_out
);

  logic [MODE_W-1:0] mode_q;
  logic              armed_q;
  logic              trig_q;
  logic              event_q;
  logic              out_q;
  logic              hit;
  logic              fire;

  always_comb begin
    case (mode_q)
      TRG_SOFT:     hit = 1'b1;
      TRG_A_RISE:   hit = cond.ch_rise[0];
      TRG_A_FALL:   hit = cond.ch_fall[0];
      TRG_B_RISE:   hit = cond.ch_rise[1];
      TRG_B_FALL:   hit = cond.ch_fall[1];
      TRG_EXT_RISE: hit = cond.ext_rise;
      TRG_EXT_FALL: hit = cond.ext_fall;
      TRG_PATTERN:  hit = cond.pat_hit;
      default:      hit = 1'b0;
    endcase
  end

  assign fire = armed_q & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      event_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (arm) begin
      mode_q  <= mode;
      armed_q <= 1'b1;
      trig_q  <= 1'b0;
      event_q <= 1'b0;
      out_q   <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b1;
      event_q <= 1'b1;
      out_q   <= 1'b1;
    end else begin
      event_q <= 1'b0;
    end
  end

  assign armed      = armed_q;
  assign triggered  = trig_q;
  assign trig_event = event_q;
  assign trig_out   = out_q & ~pin_is_input;

  AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm) |=> !trig_event); // R10

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |=> !trig_event); // R10

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |-> (triggered && !armed)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !arm) |=> out_q); // R11

  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && !triggered)); // R2

endmodule

// File: rtl/acq_trigger_unit.sv
module acq_trigger_unit
  import acq_trig_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int DIG_W       = 8,
  parameter int NARROW_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic [3:0]          mode,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [DIG_W-1:0]    pattern,
  input  logic                interlace,
  input  logic                trig_pin_is_input,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_ch_a,
  input  logic [SAMPLE_W-1:0] smp_ch_b,
  input  logic                ttl_in,
  input  logic [DIG_W-1:0]    dig_in,
  output logic                trig_event,
  output logic                trig_out,
  output logic                armed,
  output logic                triggered
);

  trg_cond_t                  cond;
  logic [SAMPLE_W-1:0]        ch_smp [NUM_CH];
  logic                       armed_int;

  assign smp_ready = 1'b1;
  assign ch_smp[0] = smp_ch_a;
  assign ch_smp[1] = smp_ch_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    acq_trig_cross #(.SAMPLE_W(SAMPLE_W)) u_cross (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (arm),
      .enable     (armed_int),
      .smp_valid  (smp_valid),
      .smp        (ch_smp[c]),
      .level      (level),
      .cross_rise (cond.ch_rise[c]),
      .cross_fall (cond.ch_fall[c])
    );
  end

  acq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (ttl_in),
    .edge_rise (cond.ext_rise),
    .edge_fall (cond.ext_fall)
  );

  acq_trig_match #(.DIG_W(DIG_W), .NARROW_W(NARROW_W)) u_match (
    .dig_in  (dig_in),
    .pattern (pattern),
    .narrow  (interlace),
    .hit     (cond.pat_hit)
  );

  acq_trig_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .mode         (mode),
    .cond         (cond),
    .pin_is_input (trig_pin_is_input),
    .armed        (armed_int),
    .triggered    (triggered),
    .trig_event   (trig_event),
    .trig_out     (trig_out)
  );

  assign armed = armed_int;

  AST_OUT_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_event && !trig_pin_is_input) |-> trig_out); // R11

endmodule

// File: tb/acq_trigger_unit_tb.sv
module acq_trigger_unit_tb;

  localparam int SW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [3:0]    mode = '0;
  logic [SW-1:0] level = '0;
  logic [DW-1:0] pattern = '0;
  logic          interlace = 1'b0;
  logic          pin_in = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_ready;
  logic [SW-1:0] ch_a = '0;
  logic [SW-1:0] ch_b = '0;
  logic          ttl = 1'b0;
  logic [DW-1:0] dig = '0;
  logic          trig_event, trig_out, armed, triggered;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  acq_trigger_unit #(.SAMPLE_W(SW), .DIG_W(DW), .NARROW_W(4), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .level(level),
    .pattern(pattern), .interlace(interlace), .trig_pin_is_input(pin_in),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_ch_a(ch_a), .smp_ch_b(ch_b),
    .ttl_in(ttl), .dig_in(dig), .trig_event(trig_event), .trig_out(trig_out),
    .armed(armed), .triggered(triggered)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic arm_with(input logic [3:0] m);
    arm = 1'b1;
    mode = m;
    step();
    arm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    // R1 reset state
    check("R1 event", trig_event, 1'b0);
    check("R1 out", trig_out, 1'b0);
    check("R1 armed", armed, 1'b0);
    check("R1 triggered", triggered, 1'b0);
    check("R1 ready", smp_ready, 1'b1);
    rst_n = 1'b1;
    step();
    check("R10 idle no fire", trig_event, 1'b0);

    // R2 / R3 software start
    arm_with(4'd0);
    check("R2 armed", armed, 1'b1);
    check("R2 not triggered", triggered, 1'b0);
    step();
    check("R3 soft event", trig_event, 1'b1);
    check("R11 out rises", trig_out, 1'b1);
    check("R10 disarmed", armed, 1'b0);
    check("R10 flag", triggered, 1'b1);
    step();
    check("R10 single pulse", trig_event, 1'b0);
    check("R11 out held", trig_out, 1'b1);
    pin_in = 1'b1;
    #1;
    check("R11 suppressed", trig_out, 1'b0);
    pin_in = 1'b0;

    // R10: conditions after firing ignored
    pattern = 8'h3C;
    dig = 8'h3C;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R10 ignore after fire", trig_event, 1'b0);
    end

    // R11 suppression at fire time
    pin_in = 1'b1;
    arm_with(4'd0);
    check("R11 cleared on arm", trig_out, 1'b0);
    step();
    check("R11 event while input", trig_event, 1'b1);
    check("R11 out suppressed", trig_out, 1'b0);
    pin_in = 1'b0;

    // R2 unused codes never fire
    for (int m = 8; m < 16; m++) begin
      arm_with(4'(m));
      for (int k = 0; k < 3; k++) begin
        step();
        check("R2 unused code", trig_event, 1'b0);
      end
    end

    // R4 R5 R6 crossing sweep on both channels
    for (int md = 1; md <= 4; md++) begin
      for (int li = 0; li < 5; li++) begin
        int lv;
        case (li)
          0: lv = -8;
          1: lv = -1;
          2: lv = 0;
          3: lv = 3;
          default: lv = 7;
        endcase
        for (int a = -8; a < 8; a++) begin
          for (int b = -8; b < 8; b++) begin
            logic exp;
            logic rising;
            logic sel_b;
            rising = (md == 1 || md == 3);
            sel_b  = (md >= 3);
            exp = rising ? (a < lv && b >= lv) : (a >= lv && b < lv);
            level = SW'(lv);
            smp_valid = 1'b0;
            arm_with(4'(md));
            smp_valid = 1'b1;
            if (sel_b) begin ch_b = SW'(a); ch_a = SW'(b); end
            else       begin ch_a = SW'(a); ch_b = SW'(b); end
            step();
            check("R6 first beat", trig_event, 1'b0);
            if (sel_b) begin ch_b = SW'(b); ch_a = SW'(a); end
            else       begin ch_a = SW'(b); ch_b = SW'(a); end
            step();
            if (rising) check("R4 rising cross", trig_event, exp);
            else        check("R5 falling cross", trig_event, exp);
            smp_valid = 1'b0;
          end
        end
      end
    end

    // R12 idle beats are not samples
    level = 4'd0;
    arm_with(4'd1);
    smp_valid = 1'b1; ch_a = 4'hE; ch_b = 4'h0;
    step();
    smp_valid = 1'b0; ch_a = 4'h5;
    step();
    check("R12 invalid beat ignored", trig_event, 1'b0);
    smp_valid = 1'b1; ch_a = 4'hF;
    step();
    check("R12 still below", trig_event, 1'b0);
    ch_a = 4'h2;
    step();
    check("R12 cross across gap", trig_event, 1'b1);
    check("R12 ready", smp_ready, 1'b1);
    smp_valid = 1'b0;

    // R7 TTL rising, timing through synchronizer
    ttl = 1'b0;
    repeat (4) step();
    arm_with(4'd5);
    ttl = 1'b1;
    step();
    check("R7 edge+1", trig_event, 1'b0);
    step();
    check("R7 edge+2", trig_event, 1'b0);
    step();
    check("R7 rise fires", trig_event, 1'b1);
    ttl = 1'b0;
    repeat (3) step();
    ttl = 1'b1;
    repeat (4) begin
      step();
      check("R10 ttl after fire", trig_event, 1'b0);
    end

    // R7 TTL falling mode: rising edge ignored, falling edge fires
    arm_with(4'd6);
    ttl = 1'b0;
    step();
    step();
    check("R7 fall edge+2", trig_event, 1'b0);
    step();
    check("R7 fall fires", trig_event, 1'b1);
    arm_with(4'd6);
    ttl = 1'b1;
    repeat (4) begin
      step();
      check("R7 wrong edge ignored", trig_event, 1'b0);
    end
    ttl = 1'b0;
    repeat (3) step();

    // R8 R9 pattern sweep, both widths
    pattern = 8'hA5;
    for (int il = 0; il < 2; il++) begin
      interlace = il[0];
      for (int d = 0; d < 256; d++) begin
        logic exp;
        dig = 8'(d);
        exp = il ? (d[3:0] == 4'h5) : (d == 8'hA5);
        arm_with(4'd7);
        step();
        if (il) check("R9 narrow compare", trig_event, exp);
        else    check("R8 wide compare", trig_event, exp);
      end
    end

    // R8 armed, then pattern appears
    interlace = 1'b0;
    dig = 8'h00;
    arm_with(4'd7);
    step();
    check("R8 waiting", trig_event, 1'b0);
    dig = 8'hA5;
    step();
    check("R8 later match", trig_event, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule